// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Power-Up Settle Gating

This block collects interrupt requests into one 32-bit main pending register and three secondary 32-bit banks: a USB core bank, a DMA bank and a GPIO bank. Software reaches every bank over a small word-addressed register bus. The bus has one write port and one independent read port. Each bank has three write actions: OR bits into the pending register, drop the bits written as one, and load a new mask. Reading a bank's source, set or clear word returns that bank's pending bits.

The USB core bank and the DMA bank roll up into fixed bits of the main pending register. The GPIO bank does not. A single interrupt line is driven from the unmasked main bits, with a selectable active level. The line is forced low from the moment the power input rises until a configurable number of clock cycles has passed with power still present.

Address map, in word offsets. Offset 0 is the configuration word. Bank b (0 = main, 1 = USB core, 2 = DMA, 3 = GPIO) occupies offsets 1+4b to 4+4b, in the order source, set, clear, mask.

Top module: `irq_aggregator`

## Requirements
- R1: Reading the source, set or clear offset of a bank returns its pending word. Reading its mask offset returns its mask. Reading offset 0 returns the configuration word. Every other offset reads as zero. Writes to a source offset or to an unmapped offset change nothing.
- R2: A write to a bank's set offset ORs the written data into that bank's pending word.
- R3: A write to a bank's clear offset zeroes every pending bit written as one and leaves the other bits alone.
- R4: A write to a bank's mask offset replaces that bank's mask with the written data.
- R5: Every set, clear or mask write to the USB core bank recomputes two main pending bits. Main bit 9 becomes one exactly when some bit in core bits 15..0 is pending and unmasked. Main bit 8 does the same for core bits 31..16.
- R6: Every set, clear or mask write to the DMA bank sets main pending bit 24 when some DMA bit is pending and unmasked, and clears it otherwise.
- R7: Writes to the GPIO bank change only the GPIO pending and mask words. The main pending word and irq_o are unaffected.
- R8: With configuration bit 17 set, irq_o is high while any main bit is pending and unmasked. With bit 17 clear, irq_o is high while no main bit is pending and unmasked. In both cases irq_o is low unless the power qualifier is ready.
- R9: After reset, the main mask is all ones. All pending words, the other three masks and the configuration word are zero, and irq_o is low.
- R10: After pwr_i is sampled high following a low sample, the qualifier is not ready. It becomes ready on the SETTLE_CYC-th clock edge after that sample, provided pwr_i stayed high.
- R11: pwr_i sampled low makes the qualifier not ready at that edge. A settle count under way is abandoned, so a later rise restarts the full count.
- R12: irq_o is registered. It takes its new value on the same clock edge that commits the register write changing its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_i | input | 1 | Power-present level |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write word offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read word offset |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Aggregated interrupt line |

## Verification
A corrupted pending or mask bit in the main bank shows on irq_o at the very edge that commits the offending write. It also shows on the main source word at the next read. A wrong rollup is visible the same way one edge after a core or DMA write, as a main bit 8, 9 or 24 that disagrees with the secondary bank's pending and mask words. A faulty settle counter shows as irq_o rising one or more edges early or late after pwr_i rises. It can also show as irq_o rising after an abandoned settle window.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DW        = 32;
    localparam int NBANK     = 4;

    localparam int BK_MAIN   = 0;
    localparam int BK_CORE   = 1;
    localparam int BK_DMA    = 2;
    localparam int BK_GPIO   = 3;

    localparam int POL_BIT   = 17;
    localparam int CORE_TX_B = 9;
    localparam int CORE_RX_B = 8;
    localparam int DMA_B     = 24;

    typedef enum logic [1:0] {
        OP_SRC = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_MSK = 2'd3
    } bank_op_e;

    typedef struct packed {
        logic [DW-1:0] pend;
        logic [DW-1:0] mask;
    } bank_st_t;

endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_agg_pkg::*;
#(
    parameter logic [DW-1:0] MASK_RST = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  bank_op_e      op_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] frc_en_i,
    input  logic [DW-1:0] frc_val_i,
    output logic [DW-1:0] pend_o,
    output logic [DW-1:0] mask_o,
    output logic [DW-1:0] pend_nx_o,
    output logic [DW-1:0] mask_nx_o
);

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            unique case (op_i)
                OP_SET:  st_d.pend = st_q.pend | wdata_i;
                OP_CLR:  st_d.pend = st_q.pend & ~wdata_i;
                OP_MSK:  st_d.mask = wdata_i;
                default: ;
            endcase
        end
        st_d.pend = (st_d.pend & ~frc_en_i) | (frc_val_i & frc_en_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pend <= '0;
            st_q.mask <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o    = st_q.pend;
    assign mask_o    = st_q.mask;
    assign pend_nx_o = st_d.pend;
    assign mask_nx_o = st_d.mask;

    // R2
    set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && op_i == OP_SET && frc_en_i == '0)
            |=> ((pend_o & $past(wdata_i)) == $past(wdata_i)));

    // R3
    clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && op_i == OP_CLR && frc_en_i == '0)
            |=> ((pend_o & $past(wdata_i)) == '0));

    // R4
    mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && op_i == OP_MSK) |=> (mask_o == $past(wdata_i)));

endmodule

// File: rtl/irq_pwr_gate.sv
module irq_pwr_gate #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwr_i,
    output logic rdy_o,
    output logic rdy_nx_o
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic          pwr;
        logic [CW-1:0] cnt;
        logic          rdy;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pwr = pwr_i;
        if (!pwr_i) begin
            st_d.rdy = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.pwr) begin
            st_d.rdy = 1'b0;
            st_d.cnt = CW'(SETTLE_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdy_o    = st_q.rdy;
    assign rdy_nx_o = st_d.rdy;

    // R11
    pwr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_i |=> !rdy_o);

    // R10
    pwr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwr_i) |=> !rdy_o);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int SETTLE_CYC = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwr_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DW-1:0]     rd_data_o,
    output logic              irq_o
);

    localparam int BSEL_W = ADDR_W - 2;

    typedef struct packed {
        logic [DW-1:0] cfg;
        logic          irq;
    } top_st_t;

    top_st_t st_d, st_q;

    // write decode: offset-1 splits into bank index and operation
    logic [ADDR_W-1:0] wr_rel, rd_rel;
    logic [BSEL_W-1:0] wr_bank, rd_bank;
    bank_op_e          wr_op, rd_op;
    logic [NBANK-1:0]  bank_we;
    logic              cfg_we;

    assign wr_rel  = wr_addr_i - ADDR_W'(1);
    assign rd_rel  = rd_addr_i - ADDR_W'(1);
    assign wr_bank = wr_rel[ADDR_W-1:2];
    assign rd_bank = rd_rel[ADDR_W-1:2];
    assign wr_op   = bank_op_e'(wr_rel[1:0]);
    assign rd_op   = bank_op_e'(rd_rel[1:0]);
    assign cfg_we  = wr_en_i && (wr_addr_i == '0);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_we
            assign bank_we[b] = wr_en_i && (wr_addr_i != '0)
                                && (wr_bank == BSEL_W'(b));
        end
    endgenerate

    // secondary banks
    logic [DW-1:0] sec_pend [1:NBANK-1];
    logic [DW-1:0] sec_mask [1:NBANK-1];
    logic [DW-1:0] sec_pnx  [1:NBANK-1];
    logic [DW-1:0] sec_mnx  [1:NBANK-1];

    generate
        for (genvar b = 1; b < NBANK; b++) begin : g_sec
            irq_bank #(.MASK_RST('0)) i_bank (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .wr_en_i   (bank_we[b]),
                .op_i      (wr_op),
                .wdata_i   (wr_data_i),
                .frc_en_i  ('0),
                .frc_val_i ('0),
                .pend_o    (sec_pend[b]),
                .mask_o    (sec_mask[b]),
                .pend_nx_o (sec_pnx[b]),
                .mask_nx_o (sec_mnx[b])
            );
        end
    endgenerate

    // rollup of core and DMA banks into main pending bits
    logic          core_hit, dma_hit;
    logic [DW-1:0] core_act, dma_act;
    logic [DW-1:0] frc_en, frc_val;

    assign core_hit = bank_we[BK_CORE] && (wr_op != OP_SRC);
    assign dma_hit  = bank_we[BK_DMA]  && (wr_op != OP_SRC);
    assign core_act = sec_pnx[BK_CORE] & ~sec_mnx[BK_CORE];
    assign dma_act  = sec_pnx[BK_DMA]  & ~sec_mnx[BK_DMA];

    always_comb begin
        frc_en  = '0;
        frc_val = '0;
        if (core_hit) begin
            frc_en[CORE_TX_B]  = 1'b1;
            frc_en[CORE_RX_B]  = 1'b1;
            frc_val[CORE_TX_B] = |core_act[DW/2-1:0];
            frc_val[CORE_RX_B] = |core_act[DW-1:DW/2];
        end
        if (dma_hit) begin
            frc_en[DMA_B]  = 1'b1;
            frc_val[DMA_B] = |dma_act;
        end
    end

    // main bank
    logic [DW-1:0] main_pend, main_mask, main_pnx, main_mnx;

    irq_bank #(.MASK_RST('1)) i_main (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (bank_we[BK_MAIN]),
        .op_i      (wr_op),
        .wdata_i   (wr_data_i),
        .frc_en_i  (frc_en),
        .frc_val_i (frc_val),
        .pend_o    (main_pend),
        .mask_o    (main_mask),
        .pend_nx_o (main_pnx),
        .mask_nx_o (main_mnx)
    );

    // power qualifier
    logic rdy_q, rdy_nx;

    irq_pwr_gate #(.SETTLE_CYC(SETTLE_CYC)) i_gate (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pwr_i    (pwr_i),
        .rdy_o    (rdy_q),
        .rdy_nx_o (rdy_nx)
    );

    // next state: configuration and output line
    logic any_nx;

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.cfg = wr_data_i;
        any_nx   = |(main_pnx & ~main_mnx);
        st_d.irq = rdy_nx && (st_d.cfg[POL_BIT] ? any_nx : !any_nx);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // read mux
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == '0) begin
            rd_data_o = st_q.cfg;
        end else if (rd_bank == BSEL_W'(BK_MAIN)) begin
            rd_data_o = (rd_op == OP_MSK) ? main_mask : main_pend;
        end else begin
            for (int b = 1; b < NBANK; b++) begin
                if (rd_bank == BSEL_W'(b))
                    rd_data_o = (rd_op == OP_MSK) ? sec_mask[b] : sec_pend[b];
            end
        end
    end

    // R8
    irq_needs_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> rdy_q);

    // R6
    dma_roll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_hit |=> (main_pend[DMA_B] == |(sec_pend[BK_DMA] & ~sec_mask[BK_DMA])));

    // R5
    core_roll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_hit |=> (main_pend[CORE_TX_B]
                      == |(sec_pend[BK_CORE][DW/2-1:0] & ~sec_mask[BK_CORE][DW/2-1:0])));

    // R7
    gpio_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bank_we[BK_GPIO] |=> (main_pend == $past(main_pend)));

endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;

    localparam int AW = 5;
    localparam int SC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] waddr = '0;
    logic [31:0]   wdata = '0;
    logic [AW-1:0] raddr = '0;
    logic [31:0]   rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    irq_aggregator #(.ADDR_W(AW), .SETTLE_CYC(SC)) i_irq_aggregator (
        .clk_i(clk), .rst_ni(rst_n), .pwr_i(pwr),
        .wr_en_i(we), .wr_addr_i(waddr), .wr_data_i(wdata),
        .rd_addr_i(raddr), .rd_data_o(rdata), .irq_o(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_pend [4];
    logic [31:0] m_mask [4];
    logic [31:0] m_cfg;
    bit          m_rdy;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic bit exp_irq();
        bit any = |(m_pend[0] & ~m_mask[0]);
        return m_rdy && (m_cfg[17] ? any : !any);
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        int b, op;
        if (a == 0) return m_cfg;
        b  = (a - 1) / 4;
        op = (a - 1) % 4;
        if (b > 3) return 32'h0;
        return (op == 3) ? m_mask[b] : m_pend[b];
    endfunction

    function automatic void model_wr(int a, logic [31:0] d);
        int b, op;
        logic [31:0] act;
        if (a == 0) begin m_cfg = d; return; end
        b  = (a - 1) / 4;
        op = (a - 1) % 4;
        if (b > 3 || op == 0) return;
        if (op == 1) m_pend[b] = m_pend[b] | d;
        if (op == 2) m_pend[b] = m_pend[b] & ~d;
        if (op == 3) m_mask[b] = d;
        act = m_pend[b] & ~m_mask[b];
        if (b == 1) begin
            m_pend[0][9] = |act[15:0];
            m_pend[0][8] = |act[31:16];
        end
        if (b == 2) m_pend[0][24] = |act;
    endfunction

    function automatic string tag_of(int a);
        int b, op;
        if (a == 0) return "R1";
        b  = (a - 1) / 4;
        op = (a - 1) % 4;
        if (b > 3 || op == 0) return "R1";
        if (b == 1) return "R5";
        if (b == 2) return "R6";
        if (b == 3) return "R7";
        if (op == 1) return "R2";
        if (op == 2) return "R3";
        return "R4";
    endfunction

    task automatic rd_chk(int a, string req);
        logic [31:0] e;
        raddr = AW'(a);
        #0.5;
        e = exp_rd(a);
        check(rdata === e, req, rdata, e);
    endtask

    // called at a negedge; returns at the following negedge
    task automatic wr(int a, logic [31:0] d, string irq_req);
        we = 1'b1; waddr = AW'(a); wdata = d;
        @(posedge clk);
        model_wr(a, d);
        @(negedge clk);
        we = 1'b0;
        check(irq === exp_irq(), irq_req, {31'b0, irq}, {31'b0, exp_irq()});
        rd_chk(1, tag_of(a));
        rd_chk(a, tag_of(a));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 4; b++) begin m_pend[b] = '0; m_mask[b] = '0; end
        m_mask[0] = 32'hFFFF_FFFF;
        m_cfg = '0;
        m_rdy = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset values
        check(irq === 1'b0, "R9", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 20; a++) rd_chk(a, "R9");
        rd_chk(4, "R9");

        // R10: settle window, R8 (no pending, level-low polarity => irq = ready)
        pwr = 1'b1;
        for (int k = 1; k <= SC + 1; k++) begin
            @(negedge clk);
            check(irq === (k == SC + 1), "R10", {31'b0, irq}, {31'b0, (k == SC + 1)});
        end
        m_rdy = 1;

        // R11: drop, then an abandoned window
        pwr = 1'b0;
        @(negedge clk);
        check(irq === 1'b0, "R11", {31'b0, irq}, 32'h0);
        pwr = 1'b1;
        repeat (SC / 2) @(negedge clk);
        pwr = 1'b0;
        repeat (SC) @(negedge clk);
        check(irq === 1'b0, "R11", {31'b0, irq}, 32'h0);
        pwr = 1'b1;
        repeat (SC) @(negedge clk);
        check(irq === 1'b0, "R10", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check(irq === 1'b1, "R10", {31'b0, irq}, 32'h1);

        // directed
        wr(4, 32'h0, "R8");
        wr(2, 32'h0000_0008, "R12");
        check(irq === 1'b0, "R12", {31'b0, irq}, 32'h0);
        wr(0, 32'h0002_0000, "R8");
        check(irq === 1'b1, "R8", {31'b0, irq}, 32'h1);
        wr(3, 32'h0000_0008, "R3");
        wr(1, 32'hFFFF_FFFF, "R1");
        wr(6, 32'h0000_0004, "R5");
        raddr = AW'(1); #0.5;
        check(rdata === 32'h0000_0200, "R5", rdata, 32'h0000_0200);
        wr(6, 32'h0010_0000, "R5");
        raddr = AW'(1); #0.5;
        check(rdata === 32'h0000_0300, "R5", rdata, 32'h0000_0300);
        wr(8, 32'h0000_FFFF, "R5");
        raddr = AW'(1); #0.5;
        check(rdata === 32'h0000_0100, "R5", rdata, 32'h0000_0100);
        wr(7, 32'h0010_0000, "R5");
        wr(10, 32'h0000_0020, "R6");
        raddr = AW'(1); #0.5;
        check(rdata === 32'h0100_0000, "R6", rdata, 32'h0100_0000);
        wr(12, 32'h0000_0020, "R6");
        raddr = AW'(1); #0.5;
        check(rdata === 32'h0000_0000, "R6", rdata, 32'h0);
        wr(12, 32'h0, "R6");
        wr(11, 32'h0000_0020, "R6");
        wr(14, 32'h0000_00FF, "R7");
        rd_chk(13, "R7"); rd_chk(15, "R7");
        wr(16, 32'h0, "R7");
        wr(20, 32'hDEAD_BEEF, "R1");
        rd_chk(20, "R1");

        // constrained random
        for (int i = 0; i < 400; i++) begin
            int a;
            logic [31:0] d;
            a = int'($urandom_range(0, 31));
            if ($urandom_range(0, 3) == 0) a = 0;
            d = $urandom & $urandom & $urandom;
            if (a == 0) d = {14'b0, 1'($urandom), 17'($urandom & $urandom)};
            if ((a - 1) % 4 == 2) d = $urandom;
            wr(a, d, "R8");
            rd_chk(int'($urandom_range(0, 31)), "R1");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule